// File: doc/BRIEF.md
# Saturating Gain-Offset Calibration Unit

This block corrects raw analog-to-digital samples for gain and offset drift. Each accepted sample `x` is scaled by an unsigned fixed-point gain and shifted by a signed offset, giving `y = a*x + b`. The arithmetic runs on a byte-wide datapath. An 8x8 multiplier forms the partial products one per cycle. The offset is then added one byte per cycle, least significant byte first, with the carry held in a register between the bytes.

The valid output range is a positive 15-bit magnitude. When the completed sum has its top bit set (bit 7 of the most significant byte), the result is replaced by the full-scale code 7FFFh and a saturation flag is raised. Bit 7 of any lower byte plays no part in this decision. Later logic reads 7FFFh as the full-scale fault value.

Gain and offset come from a calibration path that refreshes them while samples flow. They are sampled only when a sample is accepted, so each result uses one consistent pair. The control is a four-state machine:
- IDLE: ready for a sample. IDLE→MULT on an accepted sample.
- MULT: one partial product per cycle. MULT→ADD after the last partial product.
- ADD: one offset byte per cycle. ADD→EMIT after the top byte.
- EMIT: a one-cycle result pulse. EMIT→IDLE unconditionally.

Top module: `calib_unit`

## Requirements
- R1: When no saturation occurs, the result is `out_data = ((in_x * cal_gain) >> 15)[15:0] + cal_offset` modulo 2^16, with `out_sat = 0`. Here `in_x` is unsigned, `cal_gain` is unsigned with 15 fractional bits (8000h = 1.0), and `cal_offset` is two's complement.
- R2: `out_valid` goes high exactly 7 clock cycles after the edge that accepts a sample. This is 4 partial-product cycles, then 2 byte-add cycles, then 1.
- R3: When bit 15 of the 16-bit sum is 1, `out_data` is 7FFFh and `out_sat` is 1. This includes sums that wrap negative.
- R4: Bit 7 of the sum does not cause saturation. A sum of 0080h is output unchanged with `out_sat = 0`.
- R5: `out_valid` is a single-cycle pulse for each accepted sample.
- R6: `in_ready` is 1 only in IDLE. It is 0 from the accepting edge through the `out_valid` cycle and 1 again in the cycle after. `in_valid` while `in_ready` is 0 is ignored and produces no result.
- R7: Gain and offset are captured on the accepting edge. Changes to `cal_gain` or `cal_offset` while a sample is in progress do not affect its result.
- R8: During and just after reset, `in_ready` = 1, `out_valid` = 0, `out_data` = 0000h and `out_sat` = 0.
- R9: The carry out of the low-byte addition enters the high-byte addition. For example, product 00FFh plus offset 0001h gives 0100h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present on `in_x` |
| in_ready | output | 1 | Block is idle and accepts a sample this cycle |
| in_x | input | 16 | Raw unsigned sample |
| cal_gain | input | 16 | Unsigned gain, 15 fractional bits |
| cal_offset | input | 16 | Signed offset, two's complement |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Calibrated sample, or 7FFFh when clamped |
| out_sat | output | 1 | Result was clamped to full scale |

## Verification
The bench builds the block with its default widths: a 16-bit sample, an 8-bit byte lane and 15 fractional gain bits. With these values there are two bytes, four partial products and a seven-cycle latency. These settings make the important boundaries reachable with chosen operands:
- a sum whose only set bit is bit 7 of the low byte;
- a low-byte carry that ripples into the high byte;
- products and offsets that push bit 15 high, including negative wrap.

Every transaction also pulses `in_valid` while the block is busy and scrambles the calibration inputs mid-sample. This exercises the capture-at-boundary rule and the rule that inputs are ignored while busy.

// File: rtl/calib_pkg.sv
package calib_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MULT,
        ST_ADD,
        ST_EMIT
    } calib_state_e;

endpackage

// File: rtl/calib_mac_step.sv
// One partial-product step: picks a byte of x and a byte of gain,
// multiplies them on an 8x8 unit and adds the aligned product.
module calib_mac_step #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int SW     = 2
) (
    input  logic [DATA_W-1:0]   x_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [SW-1:0]       step_i,
    input  logic [2*DATA_W-1:0] acc_i,
    output logic [2*DATA_W-1:0] acc_o
);
    localparam int NB = DATA_W / BYTE_W;

    int                    xs;
    int                    as_;
    logic [BYTE_W-1:0]     xb;
    logic [BYTE_W-1:0]     ab;
    logic [2*BYTE_W-1:0]   pp;

    always_comb begin
        xs    = int'(step_i) % NB;
        as_   = int'(step_i) / NB;
        xb    = x_i[xs*BYTE_W +: BYTE_W];
        ab    = a_i[as_*BYTE_W +: BYTE_W];
        pp    = (2*BYTE_W)'(xb) * (2*BYTE_W)'(ab);
        acc_o = acc_i + ((2*DATA_W)'(pp) << ((xs + as_) * BYTE_W));
    end

endmodule

// File: rtl/calib_byte_add.sv
// Byte-wide adder with carry in and carry out.
module calib_byte_add #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic              cin_i,
    output logic [BYTE_W-1:0] sum_o,
    output logic              cout_o
);
    always_comb begin
        {cout_o, sum_o} = (BYTE_W+1)'(a_i) + (BYTE_W+1)'(b_i) + (BYTE_W+1)'(cin_i);
    end

endmodule

// File: rtl/calib_unit.sv
module calib_unit
    import calib_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_x,
    input  logic [DATA_W-1:0] cal_gain,
    input  logic [DATA_W-1:0] cal_offset,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sat
);
    localparam int NB     = DATA_W / BYTE_W;
    localparam int NSTEP  = NB * NB;
    localparam int SW     = (NSTEP > 1) ? $clog2(NSTEP) : 1;
    localparam int BW     = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [SW-1:0]     LAST_STEP = SW'(NSTEP - 1);
    localparam logic [BW-1:0]     LAST_BYTE = BW'(NB - 1);
    localparam logic [DATA_W-1:0] FULL_SCALE = {1'b0, {(DATA_W-1){1'b1}}};

    calib_state_e state_q, state_d;

    logic [DATA_W-1:0]   x_q, gain_q, off_q, sum_q, full_d;
    logic [2*DATA_W-1:0] acc_q, acc_nx;
    logic [SW-1:0]       step_q;
    logic [BW-1:0]       byte_q;
    logic                carry_q;
    logic [DATA_W-1:0]   prod_t;
    logic [BYTE_W-1:0]   add_a, add_b, add_sum;
    logic                add_cout;

    calib_mac_step #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .SW(SW)) u_mac (
        .x_i    (x_q),
        .a_i    (gain_q),
        .step_i (step_q),
        .acc_i  (acc_q),
        .acc_o  (acc_nx)
    );

    // Product truncated to the data width after dropping the fraction.
    assign prod_t = acc_q[FRAC_W +: DATA_W];

    always_comb begin
        add_a = prod_t[int'(byte_q)*BYTE_W +: BYTE_W];
        add_b = off_q[int'(byte_q)*BYTE_W +: BYTE_W];
    end

    calib_byte_add #(.BYTE_W(BYTE_W)) u_add (
        .a_i    (add_a),
        .b_i    (add_b),
        .cin_i  (carry_q),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    always_comb begin
        full_d = sum_q;
        full_d[int'(byte_q)*BYTE_W +: BYTE_W] = add_sum;
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_EMIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)                state_d = ST_MULT;
            ST_MULT: if (step_q == LAST_STEP)     state_d = ST_ADD;
            ST_ADD:  if (byte_q == LAST_BYTE)     state_d = ST_EMIT;
            ST_EMIT:                              state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q      <= '0;
            gain_q   <= '0;
            off_q    <= '0;
            acc_q    <= '0;
            sum_q    <= '0;
            step_q   <= '0;
            byte_q   <= '0;
            carry_q  <= 1'b0;
            out_data <= '0;
            out_sat  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        x_q     <= in_x;
                        gain_q  <= cal_gain;
                        off_q   <= cal_offset;
                        acc_q   <= '0;
                        sum_q   <= '0;
                        step_q  <= '0;
                        byte_q  <= '0;
                        carry_q <= 1'b0;
                    end
                end
                ST_MULT: begin
                    acc_q  <= acc_nx;
                    step_q <= step_q + 1'b1;
                end
                ST_ADD: begin
                    sum_q   <= full_d;
                    carry_q <= add_cout;
                    byte_q  <= byte_q + 1'b1;
                    if (byte_q == LAST_BYTE) begin
                        // Overflow test on the top bit of the top byte only.
                        out_sat  <= add_sum[BYTE_W-1];
                        out_data <= add_sum[BYTE_W-1] ? FULL_SCALE : full_d;
                    end
                end
                ST_EMIT: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/calib_unit_chk.sv
module calib_unit_chk #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sat
);
    localparam int NB  = DATA_W / BYTE_W;
    localparam int LAT = NB * NB + NB + 1;
    localparam logic [DATA_W-1:0] FULL_SCALE = {1'b0, {(DATA_W-1){1'b1}}};

    logic [15:0] since_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_acc <= '0;
        end else if (in_valid && in_ready) begin
            since_acc <= 16'd1;
        end else if (out_valid) begin
            since_acc <= '0;
        end else if (since_acc != 16'd0) begin
            since_acc <= since_acc + 16'd1;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_acc == 16'(LAT)));

    p_clamp_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sat) |-> (out_data == FULL_SCALE));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sat) |-> !out_data[DATA_W-1]);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_ready_after_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> in_ready);

    p_no_result_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

endmodule

bind calib_unit calib_unit_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sat   (out_sat)
);

// File: tb/calib_unit_tb.sv
`timescale 1ns/1ps
module calib_unit_tb;

    localparam int LAT = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_x = '0;
    logic [15:0] cal_gain = '0;
    logic [15:0] cal_offset = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_sat;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];
    int          acc_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    calib_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_x       (in_x),
        .cal_gain   (cal_gain),
        .cal_offset (cal_offset),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sat    (out_sat)
    );

    function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] a,
                                          input logic [15:0] b);
        logic [31:0] prod;
        logic [15:0] p;
        logic [15:0] s;
        prod = 32'(x) * 32'(a);
        p    = prod[30:15];
        s    = p + b;
        if (s[15]) return {1'b1, 16'h7FFF};
        return {1'b0, s};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one sample, then a busy-time pulse and scrambled calibration (R6, R7).
    task automatic send(input logic [15:0] x, input logic [15:0] a, input logic [15:0] b,
                        input string tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_x       = x;
        cal_gain   = a;
        cal_offset = b;
        in_valid   = 1'b1;
        exp_q.push_back(model(x, a, b));
        tag_q.push_back(tag);
        acc_q.push_back(cyc);
        @(negedge clk);
        in_x       = 16'($urandom);
        cal_gain   = 16'($urandom);
        cal_offset = 16'($urandom);
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    // Monitor / scoreboard
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                check("R5 single pulse", 32'(prev_valid), 32'd0);
                check("R6 busy during result", 32'(in_ready), 32'd0);
                if (exp_q.size() == 0) begin
                    check("R6 unexpected result", 32'd1, 32'd0);
                end else begin
                    logic [16:0] e;
                    string       t;
                    int          c;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    c = acc_q.pop_front();
                    check({t, " data"}, 32'(out_data), 32'(e[15:0]));
                    check({t, " sat"}, 32'(out_sat), 32'(e[16]));
                    check("R2 latency", 32'(cyc - c), 32'(LAT));
                end
            end else if (prev_valid) begin
                check("R6 ready after result", 32'(in_ready), 32'd1);
            end
            prev_valid <= out_valid;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset in_ready", 32'(in_ready), 32'd1);
        check("R8 reset out_valid", 32'(out_valid), 32'd0);
        check("R8 reset out_data", 32'(out_data), 32'd0);
        check("R8 reset out_sat", 32'(out_sat), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset out_valid", 32'(out_valid), 32'd0);

        send(16'h1234, 16'h8000, 16'h0000, "R1 unity gain");
        send(16'h2000, 16'h4000, 16'h0010, "R1 half gain");
        send(16'h4000, 16'hFFFF, 16'h0000, "R1 max gain");
        send(16'h0300, 16'h8000, 16'hFF00, "R1 negative offset");
        send(16'h0080, 16'h8000, 16'h0000, "R4 bit7 only");
        send(16'h0070, 16'h8000, 16'h0010, "R4 bit7 via offset");
        send(16'h00FF, 16'h8000, 16'h0001, "R9 carry");
        send(16'h7FFF, 16'h8000, 16'h0001, "R3 overflow by carry");
        send(16'hF000, 16'h8000, 16'h0000, "R3 large input");
        send(16'h0010, 16'h8000, 16'hFFE0, "R3 negative wrap");
        send(16'h6000, 16'hC000, 16'h0000, "R3 gain overflow");
        send(16'h1234, 16'h9000, 16'h0100, "R7 capture");
        for (int i = 0; i < 40; i++) begin
            send(16'($urandom), 16'($urandom), 16'($urandom), "R1 random");
        end

        repeat (LAT + 4) @(negedge clk);
        check("R6 no pending results", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule